// File: doc/BRIEF.md
# Branch Target and Next-PC Generator

This block decides where an 8-bit microcontroller with 16-bit code addresses fetches next. For each decoded control-flow instruction it is given the address of that instruction, its length in bytes, a branch kind, every operand a target can be built from, and the condition flags. It returns the next program counter, a flag telling whether control left the sequential path, and the return address that a call pushes. Stack memory and instruction fetch belong to the surrounding core.

Four kinds of target are supported. A page target replaces the low 11 bits of the address that follows the jump. A long target is a full 16-bit address. A relative target adds a signed 8-bit offset to the address that follows the instruction. An indexed target is the data pointer plus the accumulator. Conditional kinds fall through to the next sequential address when their condition is false.

Requests enter through a valid/ready handshake and results leave through one. The block holds one result in a register. A request is accepted in a cycle where `in_valid` and `in_ready` are both high, and its result is presented on the following cycle. `in_ready` is high when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result stays frozen and no new request is accepted. No request is ever dropped or reordered.

Top module: `npc_gen`

## Requirements
- R1: Kinds 1 (page jump) and 2 (page call) are taken. Their target is {(PC+2)[15:11], page_addr[10:0]}, so the page comes from the address after the 2-byte instruction, not from PC itself.
- R2: Kinds 3 (long jump) and 4 (long call) are taken, and their target is the 16-bit abs_addr.
- R3: Kind 5 (short jump) is taken. Its target is (PC+len) plus the sign-extended 8-bit offset, modulo 2^16.
- R4: out_ret_addr is (PC+len) modulo 2^16 for every kind. len is the byte count, 1 to 3, so it gives PC+2 for a page call and PC+3 for a long call.
- R5: Kind 6 (indexed jump) is taken. Its target is dptr plus the zero-extended accumulator, modulo 2^16.
- R6: The flag conditionals are kind 7 (carry=1), kind 8 (carry=0), kind 9 (bit=1), kind 10 (bit=0), kind 11 (acc==0) and kind 12 (acc!=0). When the condition holds, each takes the relative target of R3.
- R7: Kind 13 (compare) is taken when cmp_ne=1, and kind 14 (decrement) is taken when dec_nz=1. Both use the relative target of R3.
- R8: A conditional kind whose condition is false gives next PC = PC+len and taken=0. Kind 0 (sequential) and kind 15 (reserved) also give next PC = PC+len and taken=0.
- R9: While out_valid=1 and out_ready=0, the output holds all its values on the next cycle and in_ready is 0.
- R10: A request accepted with in_valid and in_ready high appears with out_valid=1 on the next cycle, and results leave in acceptance order.
- R11: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_pc | input | 16 | Address of the instruction |
| in_len | input | 2 | Instruction length in bytes (1 to 3) |
| in_kind | input | 4 | Branch kind code (see R1 to R8) |
| in_page_addr | input | 11 | In-page target bits |
| in_abs_addr | input | 16 | Long target address |
| in_rel | input | 8 | Two's complement relative offset |
| in_acc | input | 8 | Accumulator value |
| in_dptr | input | 16 | Data pointer value |
| in_cy | input | 1 | Carry flag |
| in_bit | input | 1 | Value of the addressed bit |
| in_cmp_ne | input | 1 | Compare operands were unequal |
| in_dec_nz | input | 1 | Decremented value is nonzero |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts result |
| out_next_pc | output | 16 | Next program counter |
| out_taken | output | 1 | Control left the sequential path |
| out_ret_addr | output | 16 | Return address for a call |

## Verification
The bench places a page jump at 0x17FE, where PC+2 crosses into the next 2 KB page. A design that takes the page bits from PC itself lands in the wrong page there. Relative targets are tried with offsets of -128 and +127 and from 0xFFFE. The indexed jump uses a data pointer of 0xFFF0. A design that zero-extends the offset, measures it from PC, or does not wrap modulo 2^16 gives a wrong address in these cases. Every conditional kind is run with its condition both true and false, a 3-byte call is run at 0xFFFF, and the output is held stalled while requests are pending. Swapped condition polarity, a return address computed with a fixed length, and a result lost or overwritten under back-pressure each show up as a mismatch in the scoreboard.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int KIND_W = 4;

  typedef enum logic [KIND_W-1:0] {
    BK_SEQ       = 4'd0,
    BK_PAGE_JMP  = 4'd1,
    BK_PAGE_CALL = 4'd2,
    BK_LONG_JMP  = 4'd3,
    BK_LONG_CALL = 4'd4,
    BK_SHORT     = 4'd5,
    BK_INDEX     = 4'd6,
    BK_IF_CY     = 4'd7,
    BK_IF_NCY    = 4'd8,
    BK_IF_BIT    = 4'd9,
    BK_IF_NBIT   = 4'd10,
    BK_IF_ZERO   = 4'd11,
    BK_IF_NZERO  = 4'd12,
    BK_IF_NEQ    = 4'd13,
    BK_IF_DECNZ  = 4'd14,
    BK_RSVD      = 4'd15
  } br_kind_e;

  typedef enum logic [1:0] {
    TS_REL   = 2'd0,
    TS_PAGE  = 2'd1,
    TS_LONG  = 2'd2,
    TS_INDEX = 2'd3
  } tgt_sel_e;

endpackage

// File: rtl/npc_seq_add.sv
module npc_seq_add #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 2
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] seq_addr
);
  localparam int PAD_W = ADDR_W - LEN_W;

  // Address of the instruction that follows, modulo 2^ADDR_W
  always_comb begin
    seq_addr = pc + {{PAD_W{1'b0}}, len};
  end
endmodule

// File: rtl/npc_target_calc.sv
module npc_target_calc #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 11,
  parameter int OFS_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] seq_addr,
  input  logic [PAGE_W-1:0] page_addr,
  input  logic [ADDR_W-1:0] abs_addr,
  input  logic [OFS_W-1:0]  rel,
  input  logic [DATA_W-1:0] acc,
  input  logic [ADDR_W-1:0] dptr,
  output logic [ADDR_W-1:0] tgt_page,
  output logic [ADDR_W-1:0] tgt_long,
  output logic [ADDR_W-1:0] tgt_rel,
  output logic [ADDR_W-1:0] tgt_index
);
  localparam int SEXT_W    = ADDR_W - OFS_W;
  localparam int ZEXT_W    = ADDR_W - DATA_W;
  localparam int HI_W      = ADDR_W - PAGE_W;
  localparam int PAGE_ILEN = 2;

  logic [ADDR_W-1:0] after_page_insn;
  logic [ADDR_W-1:0] rel_ext;
  logic [ADDR_W-1:0] acc_ext;

  always_comb begin
    // Page bits come from the address after the 2-byte page instruction
    after_page_insn = pc + ADDR_W'(PAGE_ILEN);
    rel_ext         = {{SEXT_W{rel[OFS_W-1]}}, rel};
    acc_ext         = {{ZEXT_W{1'b0}}, acc};
  end

  generate
    if (HI_W > 0) begin : g_paged
      always_comb tgt_page = {after_page_insn[ADDR_W-1:PAGE_W], page_addr};
    end else begin : g_flat
      always_comb tgt_page = page_addr[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    tgt_long  = abs_addr;
    tgt_rel   = seq_addr + rel_ext;
    tgt_index = dptr + acc_ext;
  end
endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [KIND_W-1:0] kind,
  input  logic              cy,
  input  logic              bit_val,
  input  logic [DATA_W-1:0] acc,
  input  logic              cmp_ne,
  input  logic              dec_nz,
  output logic              taken,
  output tgt_sel_e          sel
);
  br_kind_e k;
  logic     acc_zero;

  always_comb begin
    k        = br_kind_e'(kind);
    acc_zero = (acc == '0);
    taken    = 1'b0;
    sel      = TS_REL;
    unique case (k)
      BK_PAGE_JMP, BK_PAGE_CALL: begin taken = 1'b1;      sel = TS_PAGE;  end
      BK_LONG_JMP, BK_LONG_CALL: begin taken = 1'b1;      sel = TS_LONG;  end
      BK_INDEX:                  begin taken = 1'b1;      sel = TS_INDEX; end
      BK_SHORT:                  taken = 1'b1;
      BK_IF_CY:                  taken = cy;
      BK_IF_NCY:                 taken = ~cy;
      BK_IF_BIT:                 taken = bit_val;
      BK_IF_NBIT:                taken = ~bit_val;
      BK_IF_ZERO:                taken = acc_zero;
      BK_IF_NZERO:               taken = ~acc_zero;
      BK_IF_NEQ:                 taken = cmp_ne;
      BK_IF_DECNZ:               taken = dec_nz;
      BK_SEQ, BK_RSVD:           taken = 1'b0;
      default:                   taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_gen.sv
module npc_gen
  import npc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 11,
  parameter int OFS_W  = 8,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [ADDR_W-1:0]   in_pc,
  input  logic [LEN_W-1:0]    in_len,
  input  logic [KIND_W-1:0]   in_kind,
  input  logic [PAGE_W-1:0]   in_page_addr,
  input  logic [ADDR_W-1:0]   in_abs_addr,
  input  logic [OFS_W-1:0]    in_rel,
  input  logic [DATA_W-1:0]   in_acc,
  input  logic [ADDR_W-1:0]   in_dptr,
  input  logic                in_cy,
  input  logic                in_bit,
  input  logic                in_cmp_ne,
  input  logic                in_dec_nz,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [ADDR_W-1:0]   out_next_pc,
  output logic                out_taken,
  output logic [ADDR_W-1:0]   out_ret_addr
);
  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] tgt_page, tgt_long, tgt_rel, tgt_index;
  logic [ADDR_W-1:0] tgt_mux, npc_d;
  logic              taken_d;
  tgt_sel_e          sel;
  logic              accept;

  npc_seq_add #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .pc(in_pc), .len(in_len), .seq_addr(seq_addr)
  );

  npc_target_calc #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .OFS_W(OFS_W), .DATA_W(DATA_W)
  ) u_tgt (
    .pc(in_pc), .seq_addr(seq_addr), .page_addr(in_page_addr),
    .abs_addr(in_abs_addr), .rel(in_rel), .acc(in_acc), .dptr(in_dptr),
    .tgt_page(tgt_page), .tgt_long(tgt_long), .tgt_rel(tgt_rel),
    .tgt_index(tgt_index)
  );

  npc_cond_eval #(.DATA_W(DATA_W)) u_cond (
    .kind(in_kind), .cy(in_cy), .bit_val(in_bit), .acc(in_acc),
    .cmp_ne(in_cmp_ne), .dec_nz(in_dec_nz), .taken(taken_d), .sel(sel)
  );

  always_comb begin
    unique case (sel)
      TS_PAGE:  tgt_mux = tgt_page;
      TS_LONG:  tgt_mux = tgt_long;
      TS_INDEX: tgt_mux = tgt_index;
      default:  tgt_mux = tgt_rel;
    endcase
    npc_d    = taken_d ? tgt_mux : seq_addr;
    in_ready = ~out_valid | out_ready;
    accept   = in_valid & in_ready;
  end

  // Single result register with valid/ready hand-off
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_next_pc  <= '0;
      out_taken    <= 1'b0;
      out_ret_addr <= '0;
    end else begin
      if (accept) begin
        out_valid    <= 1'b1;
        out_next_pc  <= npc_d;
        out_taken    <= taken_d;
        out_ret_addr <= seq_addr;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/npc_gen_chk.sv
module npc_gen_chk #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 11,
  parameter int LEN_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_pc,
  input logic [LEN_W-1:0]  in_len,
  input logic [3:0]        in_kind,
  input logic [PAGE_W-1:0] in_page_addr,
  input logic [ADDR_W-1:0] in_abs_addr,
  input logic              in_cy,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_next_pc,
  input logic              out_taken,
  input logic [ADDR_W-1:0] out_ret_addr
);
  logic              fire;
  logic [ADDR_W-1:0] c_seq;
  logic [ADDR_W-1:0] c_plus2;

  always_comb begin
    fire    = in_valid && in_ready;
    c_seq   = in_pc + ADDR_W'(in_len);
    c_plus2 = in_pc + ADDR_W'(2);
  end

  p_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (in_kind == 4'd1 || in_kind == 4'd2) |=>
      out_taken && out_next_pc[PAGE_W-1:0] == $past(in_page_addr)
      && out_next_pc[ADDR_W-1:PAGE_W] == $past(c_plus2[ADDR_W-1:PAGE_W]));

  p_long_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (in_kind == 4'd3 || in_kind == 4'd4) |=>
      out_taken && out_next_pc == $past(in_abs_addr));

  p_ret_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_ret_addr == $past(c_seq));

  p_fallthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_kind == 4'd7 && !in_cy |=>
      !out_taken && out_next_pc == $past(c_seq));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=>
      out_valid && $stable(out_next_pc) && $stable(out_taken) && $stable(out_ret_addr));

  p_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);
endmodule

bind npc_gen npc_gen_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_npc_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_pc(in_pc), .in_len(in_len), .in_kind(in_kind),
  .in_page_addr(in_page_addr), .in_abs_addr(in_abs_addr), .in_cy(in_cy),
  .out_valid(out_valid), .out_ready(out_ready), .out_next_pc(out_next_pc),
  .out_taken(out_taken), .out_ret_addr(out_ret_addr)
);

// File: tb/test_npc_gen.sv
module test_npc_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_pc = '0;
  logic [1:0]  in_len = '0;
  logic [3:0]  in_kind = '0;
  logic [10:0] in_page_addr = '0;
  logic [15:0] in_abs_addr = '0;
  logic [7:0]  in_rel = '0;
  logic [7:0]  in_acc = '0;
  logic [15:0] in_dptr = '0;
  logic        in_cy = 1'b0, in_bit = 1'b0, in_cmp_ne = 1'b0, in_dec_nz = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_next_pc;
  logic        out_taken;
  logic [15:0] out_ret_addr;

  int checks = 0;
  int errors = 0;
  int sent = 0;
  int recv = 0;
  int cyc = 0;
  bit stall_mode = 1'b0;

  logic [15:0] q_npc[$];
  logic        q_tk[$];
  logic [15:0] q_ret[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  npc_gen i_npc_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_len(in_len), .in_kind(in_kind),
    .in_page_addr(in_page_addr), .in_abs_addr(in_abs_addr), .in_rel(in_rel),
    .in_acc(in_acc), .in_dptr(in_dptr), .in_cy(in_cy), .in_bit(in_bit),
    .in_cmp_ne(in_cmp_ne), .in_dec_nz(in_dec_nz), .out_valid(out_valid),
    .out_ready(out_ready), .out_next_pc(out_next_pc), .out_taken(out_taken),
    .out_ret_addr(out_ret_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected result from the requirements
  task automatic model(output logic [15:0] npc, output logic tk, output logic [15:0] ret);
    logic [15:0] seq, p2, rel_t;
    seq   = in_pc + {14'd0, in_len};
    p2    = in_pc + 16'd2;
    rel_t = seq + {{8{in_rel[7]}}, in_rel};
    ret   = seq;
    tk    = 1'b0;
    npc   = seq;
    case (in_kind)
      4'd1, 4'd2: begin tk = 1'b1; npc = {p2[15:11], in_page_addr}; end
      4'd3, 4'd4: begin tk = 1'b1; npc = in_abs_addr; end
      4'd5:  tk = 1'b1;
      4'd6:  begin tk = 1'b1; npc = in_dptr + {8'd0, in_acc}; end
      4'd7:  tk = in_cy;
      4'd8:  tk = !in_cy;
      4'd9:  tk = in_bit;
      4'd10: tk = !in_bit;
      4'd11: tk = (in_acc == 8'd0);
      4'd12: tk = (in_acc != 8'd0);
      4'd13: tk = in_cmp_ne;
      4'd14: tk = in_dec_nz;
      default: tk = 1'b0;
    endcase
    if (tk && in_kind >= 4'd5 && in_kind != 4'd6) npc = rel_t;
  endtask

  // Driver: fields already placed on in_*; hold valid until accepted
  task automatic send(input string tag);
    logic [15:0] n, r;
    logic t;
    model(n, t, r);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    q_npc.push_back(n); q_tk.push_back(t); q_ret.push_back(r); q_tag.push_back(tag);
    sent++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic setf(input logic [3:0] k, input logic [15:0] pc, input logic [1:0] len);
    in_kind = k; in_pc = pc; in_len = len;
  endtask

  // Monitor / scoreboard
  logic        prev_stall = 1'b0;
  logic [15:0] h_npc, h_ret;
  logic        h_tk;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        check("R9 hold next_pc", {16'd0, out_next_pc}, {16'd0, h_npc});
        check("R9 hold ret", {16'd0, out_ret_addr}, {16'd0, h_ret});
        check("R9 hold taken/valid", {30'd0, out_taken, out_valid}, {30'd0, h_tk, 1'b1});
      end
      prev_stall = out_valid && !out_ready;
      if (prev_stall) begin
        h_npc = out_next_pc; h_ret = out_ret_addr; h_tk = out_taken;
        check("R9 in_ready low when stalled", {31'd0, in_ready}, 32'd0);
      end
      if (out_valid && out_ready) begin
        if (q_npc.size() == 0) begin
          check("R10 unexpected output", 32'd1, 32'd0);
        end else begin
          string tg;
          tg = q_tag.pop_front();
          check({tg, " next_pc"}, {16'd0, out_next_pc}, {16'd0, q_npc.pop_front()});
          check({tg, " taken"}, {31'd0, out_taken}, {31'd0, q_tk.pop_front()});
          check({tg, " ret_addr"}, {16'd0, out_ret_addr}, {16'd0, q_ret.pop_front()});
          recv++;
        end
      end
    end
  end

  // Back-pressure pattern, changed away from sampling points
  always @(posedge clk) begin
    cyc++;
    #2;
    out_ready = stall_mode ? ((cyc % 4) == 0) : 1'b1;
  end

  // Watchdog
  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R11 in_ready after reset", {31'd0, in_ready}, 32'd1);

    // R8 sequential and reserved
    setf(4'd0, 16'h1234, 2'd1); send("R8 sequential");
    setf(4'd15, 16'h2000, 2'd3); send("R8 reserved kind");
    // R1 page jump across a page boundary, page call
    in_page_addr = 11'h123;
    setf(4'd1, 16'h17FE, 2'd2); send("R1 page jump boundary");
    in_page_addr = 11'h7FF;
    setf(4'd2, 16'h0402, 2'd2); send("R1 R4 page call");
    // R2 long
    in_abs_addr = 16'hBEEF;
    setf(4'd3, 16'h0010, 2'd3); send("R2 long jump");
    setf(4'd4, 16'hFFFF, 2'd3); send("R2 R4 long call wrap");
    // R3 relative
    in_rel = 8'h80; setf(4'd5, 16'h0100, 2'd2); send("R3 offset -128");
    in_rel = 8'h7F; setf(4'd5, 16'h0100, 2'd2); send("R3 offset +127");
    in_rel = 8'h05; setf(4'd5, 16'hFFFE, 2'd2); send("R3 wrap");
    // R5 indexed
    in_acc = 8'h20; in_dptr = 16'hFFF0; setf(4'd6, 16'h3000, 2'd1); send("R5 indexed wrap");
    in_acc = 8'hFF; in_dptr = 16'h1000; setf(4'd6, 16'h3000, 2'd1); send("R5 indexed");

    stall_mode = 1'b1;
    // R6 flag conditionals, both outcomes
    in_rel = 8'hF0;
    in_cy = 1'b1; setf(4'd7, 16'h0200, 2'd2); send("R6 carry set taken");
    in_cy = 1'b0; setf(4'd7, 16'h0200, 2'd2); send("R8 carry set not taken");
    setf(4'd8, 16'h0300, 2'd2); send("R6 carry clear taken");
    in_cy = 1'b1; setf(4'd8, 16'h0300, 2'd2); send("R8 carry clear not taken");
    in_bit = 1'b1; setf(4'd9, 16'h0400, 2'd3); send("R6 bit set taken");
    setf(4'd10, 16'h0400, 2'd3); send("R8 bit clear not taken");
    in_bit = 1'b0; setf(4'd10, 16'h0400, 2'd3); send("R6 bit clear taken");
    in_acc = 8'h00; setf(4'd11, 16'h0500, 2'd2); send("R6 acc zero taken");
    setf(4'd12, 16'h0500, 2'd2); send("R8 acc nonzero not taken");
    in_acc = 8'h01; setf(4'd12, 16'h0500, 2'd2); send("R6 acc nonzero taken");
    setf(4'd11, 16'h0500, 2'd2); send("R8 acc zero not taken");
    stall_mode = 1'b0;
    // R7 compare and decrement
    in_rel = 8'h10;
    in_cmp_ne = 1'b1; setf(4'd13, 16'h0600, 2'd3); send("R7 compare unequal");
    in_cmp_ne = 1'b0; setf(4'd13, 16'h0600, 2'd3); send("R7 compare equal");
    in_dec_nz = 1'b1; setf(4'd14, 16'h0700, 2'd2); send("R7 decrement nonzero len2");
    setf(4'd14, 16'h0700, 2'd3); send("R7 decrement nonzero len3");
    in_dec_nz = 1'b0; setf(4'd14, 16'h0700, 2'd2); send("R7 decrement zero");

    repeat (20) @(negedge clk);
    check("R10 all results delivered", recv, sent);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule